// File: doc/BRIEF.md
# Power-Saving Mode Controller

This block decides which clocks, oscillators and supplies of a small processor system are alive. Software issues a power-save command carrying a one-bit mode code. From Run the controller moves to Idle, where only the CPU clock stops, or to Sleep, where the main oscillator is switched off and the I/O pads are frozen. It moves to Deep Sleep instead when an arm bit was set before the Sleep command; Deep Sleep additionally powers down the memories. An enabled interrupt or a watchdog time-out brings the system back. A reset does the same, and the status register records a reset as a wake cause.

After Sleep or Deep Sleep the main oscillator is restarted, and the CPU and peripheral clocks wait out a fixed restart delay. The clock-source selection that was active when Run was left is held until Run resumes. The controller also enables the low-power oscillator when the watchdog or the real-time clock depends on it. It issues a one-cycle watchdog clear on Sleep entry, and the clock-failure monitor runs only while the main oscillator is stable.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in Run: cpuClkEn, periphClkEn, mainOscEn and clkMonEn are 1; ioFreeze, memPwrDn, wdtClr and deepArm are 0; wakeCause is 3'b100.
- R2: A command (cmdValid=1) with cmdMode=1 accepted in Run enters Idle on that edge: cpuClkEn=0, periphClkEn=1, mainOscEn=1, ioFreeze=0, memPwrDn=0.
- R3: A command with cmdMode=0 in Run while deepArm=0 enters Sleep on that edge: cpuClkEn, periphClkEn and mainOscEn are 0, ioFreeze=1, memPwrDn=0.
- R4: A command with cmdMode=0 in Run while deepArm=1 enters Deep Sleep: Sleep gating plus memPwrDn=1.
- R5: Commands that arrive in any state other than Run are ignored and the outputs are left unchanged.
- R6: In a low-power state, a wake happens on any irqReq bit whose irqEn bit is set, or on wdtTimeout. Requests with their enable clear cause no wake. A wake from Idle returns to Run on the same edge.
- R7: A wake from Sleep or Deep Sleep raises mainOscEn and clears memPwrDn on the wake edge, keeps ioFreeze high, and keeps cpuClkEn and periphClkEn low. Both clocks return exactly RESTART_CYC (4) edges after the wake edge.
- R8: wdtClr is high for exactly the first cycle of Sleep or Deep Sleep when wdtEn=1. It never pulses on Idle entry or when wdtEn=0.
- R9: lpOscEn equals wdtEn OR (rtcEn AND rtcOnLpOsc) in every state.
- R10: In wakeCause, bit 0 means interrupt, bit 1 means watchdog time-out and bit 2 means reset. A wake sets the matching bits. An edge with wakeRd=1 clears the register, unless a wake sets bits on that same edge, in which case the set wins.
- R11: deepArm is set by a deepArmSet pulse and cleared on the wake edge from any low-power state.
- R12: activeClkSel takes clkSelReq on every edge in Run and holds its value in every other state.
- R13: clkMonEn is 1 only in Run and Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Power-save command strobe |
| cmdMode | input | 1 | Mode code: 0 Sleep, 1 Idle |
| deepArmSet | input | 1 | Sets the Deep Sleep arm bit |
| irqReq | input | N_IRQ | Interrupt requests |
| irqEn | input | N_IRQ | Per-source interrupt enables |
| wdtEn | input | 1 | Watchdog enabled |
| wdtTimeout | input | 1 | Watchdog time-out |
| rtcEn | input | 1 | Real-time clock enabled |
| rtcOnLpOsc | input | 1 | Real-time clock runs from the low-power oscillator |
| clkSelReq | input | CLK_SEL_W | Requested clock source |
| wakeRd | input | 1 | Read strobe that clears wakeCause |
| cpuClkEn | output | 1 | CPU clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| mainOscEn | output | 1 | Main oscillator enable |
| lpOscEn | output | 1 | Low-power oscillator enable |
| clkMonEn | output | 1 | Clock-failure monitor enable |
| wdtClr | output | 1 | Watchdog clear pulse |
| ioFreeze | output | 1 | Freeze I/O direction and state |
| memPwrDn | output | 1 | Memory power-down |
| wakeCause | output | 3 | Wake cause {reset, watchdog, interrupt} |
| deepArm | output | 1 | Deep Sleep arm bit |
| activeClkSel | output | CLK_SEL_W | Clock source in use |

## Verification
A command or wake condition takes effect on the edge that samples it. The gating outputs, wdtClr, deepArm and wakeCause therefore show the new value one edge after the stimulus is applied. The exception is the CPU and peripheral clocks after a Sleep wake, which return on the fourth edge after the wake edge. The bench applies every stimulus a quarter period after a rising edge and compares outputs a quarter period after the next edge. It steps the restart window edge by edge and checks that the clocks stay low until the fourth edge. It sweeps all three low-power modes against every interrupt source and the watchdog, combined with watchdog and real-time clock settings, and computes each expected value from the mode and the settings.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_IDLE,
    ST_SLEEP,
    ST_DEEP,
    ST_RESTART
  } pwrState_e;

  localparam logic MODE_SLEEP = 1'b0;
  localparam logic MODE_IDLE  = 1'b1;

  // strobes and gate levels handed from control to datapath
  typedef struct packed {
    logic cpuOn;
    logic perOn;
    logic oscOn;
    logic freeze;
    logic memOff;
    logic monOn;
    logic inRun;
    logic sleepEntry;
    logic wakeEvt;
    logic irqHit;
    logic wdtHit;
  } pwrCtl_t;

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ       = 8,
  parameter int RESTART_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdMode,
  input  logic             deepArm,
  input  logic [N_IRQ-1:0] irqReq,
  input  logic [N_IRQ-1:0] irqEn,
  input  logic             wdtTimeout,
  output pwrCtl_t          ctl
);

  localparam int CW = (RESTART_CYC > 1) ? $clog2(RESTART_CYC) : 1;

  pwrState_e      state, stateNxt;
  logic [CW-1:0]  cnt, cntNxt;
  logic [N_IRQ-1:0] irqMasked;
  logic           irqAny, wakeReq, lowPwr;

  genvar gi;
  generate
    for (gi = 0; gi < N_IRQ; gi++) begin : g_mask
      assign irqMasked[gi] = irqReq[gi] & irqEn[gi];
    end
  endgenerate

  assign irqAny  = |irqMasked;
  assign wakeReq = irqAny | wdtTimeout;
  assign lowPwr  = (state == ST_IDLE) || (state == ST_SLEEP) || (state == ST_DEEP);

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    case (state)
      ST_RUN: begin
        if (cmdValid) begin
          if (cmdMode == MODE_IDLE) stateNxt = ST_IDLE;
          else if (deepArm)         stateNxt = ST_DEEP;
          else                      stateNxt = ST_SLEEP;
        end
      end
      ST_IDLE: begin
        if (wakeReq) stateNxt = ST_RUN;
      end
      ST_SLEEP, ST_DEEP: begin
        if (wakeReq) begin
          stateNxt = ST_RESTART;
          cntNxt   = CW'(RESTART_CYC - 1);
        end
      end
      ST_RESTART: begin
        if (cnt == '0) stateNxt = ST_RUN;
        else           cntNxt   = cnt - CW'(1);
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  always_comb begin
    ctl = '0;
    ctl.sleepEntry = (state == ST_RUN) && cmdValid && (cmdMode == MODE_SLEEP);
    ctl.wakeEvt    = lowPwr && wakeReq;
    ctl.irqHit     = irqAny;
    ctl.wdtHit     = wdtTimeout;
    case (state)
      ST_RUN: begin
        ctl.cpuOn = 1'b1; ctl.perOn = 1'b1; ctl.oscOn = 1'b1;
        ctl.monOn = 1'b1; ctl.inRun = 1'b1;
      end
      ST_IDLE: begin
        ctl.perOn = 1'b1; ctl.oscOn = 1'b1; ctl.monOn = 1'b1;
      end
      ST_SLEEP: begin
        ctl.freeze = 1'b1;
      end
      ST_DEEP: begin
        ctl.freeze = 1'b1; ctl.memOff = 1'b1;
      end
      ST_RESTART: begin
        ctl.oscOn = 1'b1; ctl.freeze = 1'b1;
      end
      default: ;
    endcase
  end

  // R2: idle entry gates only the CPU
  a_r2_idle_gates: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && cmdValid && cmdMode == MODE_IDLE) |=> (!ctl.cpuOn && ctl.perOn && ctl.oscOn));

  // R3: sleep entry stops the oscillator and freezes I/O
  a_r3_sleep_gates: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && cmdValid && cmdMode == MODE_SLEEP && !deepArm)
      |=> (!ctl.oscOn && !ctl.perOn && ctl.freeze && !ctl.memOff));

  // R4: armed sleep powers down memory
  a_r4_deep_mem: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && cmdValid && cmdMode == MODE_SLEEP && deepArm) |=> ctl.memOff);

  // R5: with no wake pending a low-power state is kept whatever the command
  a_r5_hold_low: assert property (@(posedge clk) disable iff (!rstN)
    (lowPwr && !wakeReq) |=> $stable(state));

  // R7: CPU clock never returns on the edge right after the oscillator was off
  a_r7_osc_first: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.oscOn |=> !ctl.cpuOn);

  // R13: monitor only runs with the main oscillator on
  a_r13_mon_osc: assert property (@(posedge clk) disable iff (!rstN)
    ctl.monOn |-> (ctl.oscOn && !ctl.freeze));

endmodule

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int CLK_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pwrCtl_t              ctl,
  input  logic                 wdtEn,
  input  logic                 rtcEn,
  input  logic                 rtcOnLpOsc,
  input  logic                 deepArmSet,
  input  logic                 wakeRd,
  input  logic [CLK_SEL_W-1:0] clkSelReq,
  output logic                 cpuClkEn,
  output logic                 periphClkEn,
  output logic                 mainOscEn,
  output logic                 lpOscEn,
  output logic                 clkMonEn,
  output logic                 wdtClr,
  output logic                 ioFreeze,
  output logic                 memPwrDn,
  output logic [2:0]           wakeCause,
  output logic                 deepArm,
  output logic [CLK_SEL_W-1:0] activeClkSel
);

  localparam int WC_IRQ = 0;
  localparam int WC_WDT = 1;
  localparam int WC_RST = 2;

  logic [2:0] causeSet;

  assign cpuClkEn    = ctl.cpuOn;
  assign periphClkEn = ctl.perOn;
  assign mainOscEn   = ctl.oscOn;
  assign clkMonEn    = ctl.monOn;
  assign ioFreeze    = ctl.freeze;
  assign memPwrDn    = ctl.memOff;
  assign lpOscEn     = wdtEn | (rtcEn & rtcOnLpOsc);

  always_comb begin
    causeSet = '0;
    if (ctl.wakeEvt) begin
      causeSet[WC_IRQ] = ctl.irqHit;
      causeSet[WC_WDT] = ctl.wdtHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdtClr       <= 1'b0;
      wakeCause    <= 3'b1 << WC_RST;
      deepArm      <= 1'b0;
      activeClkSel <= '0;
    end else begin
      wdtClr    <= ctl.sleepEntry & wdtEn;
      wakeCause <= causeSet | (wakeRd ? 3'b000 : wakeCause);
      if (ctl.wakeEvt)  deepArm <= 1'b0;
      else if (deepArmSet) deepArm <= 1'b1;
      if (ctl.inRun) activeClkSel <= clkSelReq;
    end
  end

  // R8: clear is a single-cycle pulse and needs the watchdog enabled
  a_r8_single: assert property (@(posedge clk) disable iff (!rstN)
    wdtClr |=> !wdtClr);
  a_r8_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    wdtClr |-> $past(wdtEn));

  // R10: read clears status when no wake coincides
  a_r10_rd_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wakeRd && !ctl.wakeEvt) |=> (wakeCause == 3'b000));

  // R11: arm bit drops on wake
  a_r11_arm_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wakeEvt |=> !deepArm);

  // R12: clock selection held outside Run
  a_r12_sel_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.inRun |=> $stable(activeClkSel));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ       = 8,
  parameter int CLK_SEL_W   = 2,
  parameter int RESTART_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic                 cmdMode,
  input  logic                 deepArmSet,
  input  logic [N_IRQ-1:0]     irqReq,
  input  logic [N_IRQ-1:0]     irqEn,
  input  logic                 wdtEn,
  input  logic                 wdtTimeout,
  input  logic                 rtcEn,
  input  logic                 rtcOnLpOsc,
  input  logic [CLK_SEL_W-1:0] clkSelReq,
  input  logic                 wakeRd,
  output logic                 cpuClkEn,
  output logic                 periphClkEn,
  output logic                 mainOscEn,
  output logic                 lpOscEn,
  output logic                 clkMonEn,
  output logic                 wdtClr,
  output logic                 ioFreeze,
  output logic                 memPwrDn,
  output logic [2:0]           wakeCause,
  output logic                 deepArm,
  output logic [CLK_SEL_W-1:0] activeClkSel
);

  pwrCtl_t ctl;

  pwr_mode_fsm #(.N_IRQ(N_IRQ), .RESTART_CYC(RESTART_CYC)) u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdMode    (cmdMode),
    .deepArm    (deepArm),
    .irqReq     (irqReq),
    .irqEn      (irqEn),
    .wdtTimeout (wdtTimeout),
    .ctl        (ctl)
  );

  pwr_mode_dp #(.CLK_SEL_W(CLK_SEL_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .wdtEn        (wdtEn),
    .rtcEn        (rtcEn),
    .rtcOnLpOsc   (rtcOnLpOsc),
    .deepArmSet   (deepArmSet),
    .wakeRd       (wakeRd),
    .clkSelReq    (clkSelReq),
    .cpuClkEn     (cpuClkEn),
    .periphClkEn  (periphClkEn),
    .mainOscEn    (mainOscEn),
    .lpOscEn      (lpOscEn),
    .clkMonEn     (clkMonEn),
    .wdtClr       (wdtClr),
    .ioFreeze     (ioFreeze),
    .memPwrDn     (memPwrDn),
    .wakeCause    (wakeCause),
    .deepArm      (deepArm),
    .activeClkSel (activeClkSel)
  );

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ      = 8;
  localparam int CSW        = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdMode = 1'b0, deepArmSet = 1'b0;
  logic [N_IRQ-1:0] irqReq = '0, irqEn = '0;
  logic wdtEn = 1'b0, wdtTimeout = 1'b0, rtcEn = 1'b0, rtcOnLpOsc = 1'b0;
  logic [CSW-1:0] clkSelReq = '0;
  logic wakeRd = 1'b0;
  logic cpuClkEn, periphClkEn, mainOscEn, lpOscEn, clkMonEn, wdtClr;
  logic ioFreeze, memPwrDn, deepArm;
  logic [2:0] wakeCause;
  logic [CSW-1:0] activeClkSel;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.N_IRQ(N_IRQ), .CLK_SEL_W(CSW), .RESTART_CYC(4)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdMode(cmdMode),
    .deepArmSet(deepArmSet), .irqReq(irqReq), .irqEn(irqEn), .wdtEn(wdtEn),
    .wdtTimeout(wdtTimeout), .rtcEn(rtcEn), .rtcOnLpOsc(rtcOnLpOsc),
    .clkSelReq(clkSelReq), .wakeRd(wakeRd), .cpuClkEn(cpuClkEn),
    .periphClkEn(periphClkEn), .mainOscEn(mainOscEn), .lpOscEn(lpOscEn),
    .clkMonEn(clkMonEn), .wdtClr(wdtClr), .ioFreeze(ioFreeze),
    .memPwrDn(memPwrDn), .wakeCause(wakeCause), .deepArm(deepArm),
    .activeClkSel(activeClkSel)
  );

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // gates packed as {cpu, per, osc, freeze, mem, mon}
  task automatic chkGates(input string tag, input int exp);
    chk(tag, {26'd0, cpuClkEn, periphClkEn, mainOscEn, ioFreeze, memPwrDn, clkMonEn}, exp);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chkGates("R1 gates", 6'b111001);
    chk("R1 wdtClr", wdtClr, 0);
    chk("R1 deepArm", deepArm, 0);
    chk("R1 wakeCause", wakeCause, 3'b100);
    wakeRd = 1'b1; tick(); wakeRd = 1'b0;
    chk("R10 read clear after reset", wakeCause, 0);

    for (int c = 0; c < 108; c++) begin
      int m = c % 3;          // 0 idle, 1 sleep, 2 deep
      int s = (c / 3) % 9;    // 0..7 irq index, 8 watchdog
      int cfg = c / 27;
      logic wE = cfg[0];
      logic rE = cfg[1];
      logic lp = s[0];
      logic [CSW-1:0] sel = CSW'(c % 4);
      int lowGates;
      wdtEn = wE; rtcEn = rE; rtcOnLpOsc = lp;
      clkSelReq = sel;
      tick();
      if (m == 2) begin
        deepArmSet = 1'b1; tick(); deepArmSet = 1'b0;
        chk("R11 arm set", deepArm, 1);
      end
      cmdValid = 1'b1; cmdMode = (m == 0); tick(); cmdValid = 1'b0;
      clkSelReq = sel ^ 2'b11;
      lowGates = (m == 0) ? 6'b011001 : (m == 1) ? 6'b000100 : 6'b000110;
      if (m == 0) chkGates("R2 idle gates", lowGates);
      else if (m == 1) chkGates("R3 sleep gates R13", lowGates);
      else chkGates("R4 deep gates R13", lowGates);
      chk("R8 clear pulse", wdtClr, (m != 0 && wE) ? 1 : 0);
      chk("R9 lp osc", lpOscEn, (wE | (rE & lp)) ? 1 : 0);
      tick();
      chk("R8 pulse ends", wdtClr, 0);
      chk("R12 sel held", activeClkSel, sel);
      cmdValid = 1'b1; cmdMode = (m != 0); tick(); cmdValid = 1'b0;
      chkGates("R5 command ignored", lowGates);
      irqReq = '1; irqEn = '0; tick(); irqReq = '0;
      chkGates("R6 masked irq", lowGates);
      if (s < N_IRQ) begin irqReq[s] = 1'b1; irqEn[s] = 1'b1; end
      else wdtTimeout = 1'b1;
      tick();
      irqReq = '0; irqEn = '0; wdtTimeout = 1'b0;
      if (m == 0) chkGates("R6 idle wake", 6'b111001);
      else begin
        chkGates("R7 restart gates", 6'b001100);
        for (int k = 0; k < 3; k++) begin
          tick();
          chk("R7 cpu held", cpuClkEn, 0);
        end
        tick();
        chkGates("R7 clocks back", 6'b111001);
      end
      chk("R11 arm cleared", deepArm, 0);
      chk("R10 cause", wakeCause, (s < N_IRQ) ? 1 : 2);
      chk("R12 sel after wake", activeClkSel, sel);
      wakeRd = 1'b1; tick(); wakeRd = 1'b0;
      chk("R10 read clears", wakeCause, 0);
      chk("R12 sel tracks in run", activeClkSel, sel ^ 2'b11);
    end

    // R10 set wins over a coincident read; R8 none on idle entry
    wdtEn = 1'b1;
    cmdValid = 1'b1; cmdMode = 1'b1; tick(); cmdValid = 1'b0;
    chk("R8 no pulse on idle", wdtClr, 0);
    wdtTimeout = 1'b1; wakeRd = 1'b1; tick(); wdtTimeout = 1'b0; wakeRd = 1'b0;
    chk("R10 set wins", wakeCause, 2);
    finish();
  end

endmodule